// File: doc/BRIEF.md
# Accumulator-Style Byte and Literal Execute Unit

This block carries out the byte-wide data operations of a small microcontroller whose instructions are 14 bits long and which keeps one working accumulator W. Each cycle it is handed one instruction word. A register-operand instruction names one of 128 byte registers and has a direction bit. The unit reads that register through a combinational read port into an external register file. It combines the value with W or transforms it, and then sends the result either to W or back to the named register. A literal instruction carries an 8-bit constant in its low byte and updates only W.

The unit supports add, subtract, AND, inclusive OR, exclusive OR, move, clear, increment, decrement and bitwise complement. For the two counting-loop instructions it also raises a skip request when the 8-bit result is zero, so the fetch logic can drop the next instruction. W is held inside the unit. Every update to W or to the register file lands on the clock edge that ends the instruction.

Top module: `acc_exec_unit`

## Requirements
- R1: Register-operand instructions hold the opcode in bits 13..8, the direction bit in bit 7 and the register number in bits 6..0. When the direction bit is 0, the result goes to W and the register file is not written.
- R2: When the direction bit is 1, the result is written to the named register (rf_we=1, rf_addr equal to the register number, rf_wdata equal to the result) and W keeps its value.
- R3: Literal instructions hold the opcode in bits 13..8 and a constant K in bits 7..0, and they set W to W op K. The codes are: 110000 move K, 111110 add, 111001 AND, 111000 OR, 111010 XOR, 111100 subtract.
- R4: The register forms use these codes: 000111 add, 000101 AND, 000100 OR, 000110 XOR. Each combines register and W bitwise or modulo 256.
- R5: Subtraction gives the register value minus W (code 000010), or K minus W for the literal form, modulo 256.
- R6: Code 000000 with bit 7 set copies W into the named register. Code 000000 with bit 7 clear writes nothing and changes nothing.
- R7: Code 000001 writes zero. With bit 7 set it clears the named register; with bit 7 clear it clears W.
- R8: Increment (001010) and decrement (001011 skip form, 000011 plain form) work modulo 256, so 255+1 gives 0. The skip forms (001011, 001111 for increment) raise skip_req only when their 8-bit result is 0. No other instruction raises it.
- R9: Code 001001 produces the bitwise inverse of the register value.
- R10: Code 001000 moves the register value to the destination chosen by bit 7.
- R11: res_zero is 1 exactly when a valid instruction writes a result equal to 0.
- R12: With instr_valid low, or with an opcode not listed above, nothing is written, W keeps its value and skip_req stays 0.
- R13: A synchronous reset clears W to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high, clears W |
| instr_valid | input | 1 | The instruction on instr executes this cycle |
| instr | input | 14 | Instruction word |
| rf_addr | output | 7 | Register-file read and write address (instr bits 6..0) |
| rf_rdata | input | 8 | Combinational read data for rf_addr |
| rf_we | output | 1 | Write the register file at the next clock edge |
| rf_wdata | output | 8 | Result to be written |
| w_q | output | 8 | Current W value |
| res_zero | output | 1 | Written result is zero |
| skip_req | output | 1 | Skip the next instruction |

## Verification
The vector walk runs a dependent program. Each instruction's expected W and register values follow from the earlier ones, so a wrong destination shows up later as a wrong operand as well as at once. Pairs of vectors that differ only in the direction bit separate the W path from the register path. Subtracting with operands in both orders shows up a swap. Register values of 0xFF, 0x01 and 0x00 separate a correct wrap and skip from a skip on the wrong instruction. Directed steps then drive a suppressed instruction, an unused opcode and a reset mid-run while W holds a nonzero value.

// File: rtl/acc_exec_pkg.sv
package acc_exec_pkg;

   localparam int OPC_W = 6;

   localparam logic [OPC_W-1:0] OPC_MISC   = 6'b000000;
   localparam logic [OPC_W-1:0] OPC_CLR    = 6'b000001;
   localparam logic [OPC_W-1:0] OPC_SUBWF  = 6'b000010;
   localparam logic [OPC_W-1:0] OPC_DECF   = 6'b000011;
   localparam logic [OPC_W-1:0] OPC_IORWF  = 6'b000100;
   localparam logic [OPC_W-1:0] OPC_ANDWF  = 6'b000101;
   localparam logic [OPC_W-1:0] OPC_XORWF  = 6'b000110;
   localparam logic [OPC_W-1:0] OPC_ADDWF  = 6'b000111;
   localparam logic [OPC_W-1:0] OPC_MOVF   = 6'b001000;
   localparam logic [OPC_W-1:0] OPC_COMF   = 6'b001001;
   localparam logic [OPC_W-1:0] OPC_INCF   = 6'b001010;
   localparam logic [OPC_W-1:0] OPC_DECFSZ = 6'b001011;
   localparam logic [OPC_W-1:0] OPC_INCFSZ = 6'b001111;
   localparam logic [OPC_W-1:0] OPC_MOVLW  = 6'b110000;
   localparam logic [OPC_W-1:0] OPC_IORLW  = 6'b111000;
   localparam logic [OPC_W-1:0] OPC_ANDLW  = 6'b111001;
   localparam logic [OPC_W-1:0] OPC_XORLW  = 6'b111010;
   localparam logic [OPC_W-1:0] OPC_SUBLW  = 6'b111100;
   localparam logic [OPC_W-1:0] OPC_ADDLW  = 6'b111110;

   typedef enum logic [3:0] {
      ALU_NONE,
      ALU_ADD,
      ALU_SUB,
      ALU_AND,
      ALU_IOR,
      ALU_XOR,
      ALU_INC,
      ALU_DEC,
      ALU_COM,
      ALU_PASS_OPND,
      ALU_PASS_W,
      ALU_ZERO
   } alu_op_e;

   typedef struct packed {
      alu_op_e op;
      logic    use_lit;
      logic    to_reg;
      logic    writes;
      logic    skip_on_zero;
   } dec_ctl_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
   import acc_exec_pkg::*;
(
   input  logic [OPC_W-1:0] opc,
   input  logic             dir_bit,
   output dec_ctl_t         ctl
);

   always_comb begin
      ctl.op           = ALU_NONE;
      ctl.use_lit      = 1'b0;
      ctl.to_reg       = 1'b0;
      ctl.writes       = 1'b0;
      ctl.skip_on_zero = 1'b0;
      unique case (opc)
         OPC_MISC: begin
            if (dir_bit) begin
               ctl.op     = ALU_PASS_W;
               ctl.to_reg = 1'b1;
               ctl.writes = 1'b1;
            end
         end
         OPC_CLR: begin
            ctl.op     = ALU_ZERO;
            ctl.to_reg = dir_bit;
            ctl.writes = 1'b1;
         end
         OPC_ADDWF, OPC_SUBWF, OPC_ANDWF, OPC_IORWF, OPC_XORWF,
         OPC_DECF, OPC_INCF, OPC_DECFSZ, OPC_INCFSZ, OPC_COMF, OPC_MOVF: begin
            ctl.to_reg = dir_bit;
            ctl.writes = 1'b1;
            unique case (opc)
               OPC_ADDWF:              ctl.op = ALU_ADD;
               OPC_SUBWF:              ctl.op = ALU_SUB;
               OPC_ANDWF:              ctl.op = ALU_AND;
               OPC_IORWF:              ctl.op = ALU_IOR;
               OPC_XORWF:              ctl.op = ALU_XOR;
               OPC_DECF, OPC_DECFSZ:   ctl.op = ALU_DEC;
               OPC_INCF, OPC_INCFSZ:   ctl.op = ALU_INC;
               OPC_COMF:               ctl.op = ALU_COM;
               default:                ctl.op = ALU_PASS_OPND;
            endcase
            ctl.skip_on_zero = (opc == OPC_DECFSZ) || (opc == OPC_INCFSZ);
         end
         OPC_MOVLW, OPC_ADDLW, OPC_SUBLW, OPC_ANDLW, OPC_IORLW, OPC_XORLW: begin
            ctl.use_lit = 1'b1;
            ctl.writes  = 1'b1;
            unique case (opc)
               OPC_ADDLW: ctl.op = ALU_ADD;
               OPC_SUBLW: ctl.op = ALU_SUB;
               OPC_ANDLW: ctl.op = ALU_AND;
               OPC_IORLW: ctl.op = ALU_IOR;
               OPC_XORLW: ctl.op = ALU_XOR;
               default:   ctl.op = ALU_PASS_OPND;
            endcase
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_exec_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  alu_op_e           op,
   input  logic [DATA_W-1:0] opnd,
   input  logic [DATA_W-1:0] w,
   output logic [DATA_W-1:0] result,
   output logic              zero
);

   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic [DATA_W-1:0] arith;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic [DATA_W-1:0] addend;
         logic [DATA_W-1:0] carry_in;
         always_comb begin
            addend   = '0;
            carry_in = '0;
            unique case (op)
               ALU_ADD: addend = w;
               ALU_SUB: begin
                  addend   = ~w;
                  carry_in = ONE;
               end
               ALU_INC: carry_in = ONE;
               ALU_DEC: addend = '1;
               default: ;
            endcase
         end
         assign arith = opnd + addend + carry_in;
      end else begin : g_split
         always_comb begin
            unique case (op)
               ALU_ADD: arith = opnd + w;
               ALU_SUB: arith = opnd - w;
               ALU_INC: arith = opnd + ONE;
               ALU_DEC: arith = opnd - ONE;
               default: arith = opnd;
            endcase
         end
      end
   endgenerate

   always_comb begin
      unique case (op)
         ALU_ADD, ALU_SUB, ALU_INC, ALU_DEC: result = arith;
         ALU_AND:       result = opnd & w;
         ALU_IOR:       result = opnd | w;
         ALU_XOR:       result = opnd ^ w;
         ALU_COM:       result = ~opnd;
         ALU_PASS_OPND: result = opnd;
         ALU_PASS_W:    result = w;
         default:       result = '0;
      endcase
   end

   assign zero = (result == '0);

endmodule

// File: rtl/acc_exec_unit.sv
module acc_exec_unit
   import acc_exec_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int ADDR_W       = 7,
   parameter int INSTR_W      = 14,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               instr_valid,
   input  logic [INSTR_W-1:0] instr,
   output logic [ADDR_W-1:0]  rf_addr,
   input  logic [DATA_W-1:0]  rf_rdata,
   output logic               rf_we,
   output logic [DATA_W-1:0]  rf_wdata,
   output logic [DATA_W-1:0]  w_q,
   output logic               res_zero,
   output logic               skip_req
);

   localparam int DIR_POS = ADDR_W;

   generate
      if (INSTR_W != OPC_W + 1 + ADDR_W) begin : g_bad_instr_w
         $error("acc_exec_unit: INSTR_W must equal opcode + direction + address bits");
      end
      if (DATA_W != ADDR_W + 1) begin : g_bad_data_w
         $error("acc_exec_unit: literal field must fill the direction and address bits");
      end
      if (DATA_W < 2) begin : g_bad_small
         $error("acc_exec_unit: DATA_W too small");
      end
   endgenerate

   logic [OPC_W-1:0]  opc;
   logic              dir_bit;
   logic [DATA_W-1:0] lit;
   logic [DATA_W-1:0] opnd;
   logic [DATA_W-1:0] alu_res;
   logic              alu_zero;
   logic              w_we;
   dec_ctl_t          ctl;

   assign opc     = instr[INSTR_W-1 -: OPC_W];
   assign dir_bit = instr[DIR_POS];
   assign lit     = instr[DATA_W-1:0];
   assign rf_addr = instr[ADDR_W-1:0];

   acc_decode u_decode (
      .opc     (opc),
      .dir_bit (dir_bit),
      .ctl     (ctl)
   );

   assign opnd = ctl.use_lit ? lit : rf_rdata;

   acc_alu #(
      .DATA_W       (DATA_W),
      .SHARED_ADDER (SHARED_ADDER)
   ) u_alu (
      .op     (ctl.op),
      .opnd   (opnd),
      .w      (w_q),
      .result (alu_res),
      .zero   (alu_zero)
   );

   assign rf_we    = instr_valid && ctl.writes && ctl.to_reg;
   assign w_we     = instr_valid && ctl.writes && !ctl.to_reg;
   assign rf_wdata = alu_res;
   assign res_zero = instr_valid && ctl.writes && alu_zero;
   assign skip_req = instr_valid && ctl.skip_on_zero && alu_zero;

   always_ff @(posedge clk) begin
      if (rst) begin
         w_q <= '0;
      end else if (w_we) begin
         w_q <= alu_res;
      end
   end

   // R12: an idle cycle drives no write, no skip and no zero report
   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
      !instr_valid |-> (!rf_we && !skip_req && !res_zero));

   // R13: reset leaves W cleared on the following cycle
   a_r13_reset_clears_w: assert property (@(posedge clk)
      rst |=> (w_q == '0));

   // R2: a register-file write leaves W untouched
   a_r2_w_holds_on_reg_write: assert property (@(posedge clk) disable iff (rst)
      rf_we |=> $stable(w_q));

   // R6: the all-zero word writes nothing and keeps W
   a_r6_nop_no_write: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && instr == '0) |-> !rf_we);
   a_r6_nop_keeps_w: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && instr == '0) |=> $stable(w_q));

   // R7: clear-W leaves zero in W
   a_r7_clrw_zero: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && opc == OPC_CLR && !dir_bit) |=> (w_q == '0));

   // R8: incrementing an all-ones register wraps to zero
   a_r8_inc_wrap: assert property (@(posedge clk) disable iff (rst)
      (instr_valid && (opc == OPC_INCF || opc == OPC_INCFSZ) && rf_rdata == '1)
      |-> res_zero);

   // R8: a skip request only accompanies a zero result
   a_r8_skip_on_zero: assert property (@(posedge clk) disable iff (rst)
      skip_req |-> (res_zero && (opc == OPC_DECFSZ || opc == OPC_INCFSZ)));

endmodule

// File: tb/acc_exec_unit_tb.sv
module acc_exec_unit_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NVEC       = 28;

   logic        clk = 1'b0;
   logic        rst;
   logic        instr_valid;
   logic [13:0] instr;
   logic [6:0]  rf_addr;
   logic [7:0]  rf_rdata;
   logic        rf_we;
   logic [7:0]  rf_wdata;
   logic [7:0]  w_q;
   logic        res_zero;
   logic        skip_req;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   logic [7:0] rf [128];

   always #(CLK_PERIOD/2) clk = ~clk;

   acc_exec_unit u_dut (
      .clk         (clk),
      .rst         (rst),
      .instr_valid (instr_valid),
      .instr       (instr),
      .rf_addr     (rf_addr),
      .rf_rdata    (rf_rdata),
      .rf_we       (rf_we),
      .rf_wdata    (rf_wdata),
      .w_q         (w_q),
      .res_zero    (res_zero),
      .skip_req    (skip_req)
   );

   // register-file model: preset on reset, written on the clock edge
   assign rf_rdata = rf[rf_addr];
   always @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < 128; i++) rf[i] <= 8'h00;
         rf[7'h20] <= 8'h06;
         rf[7'h21] <= 8'hF4;
         rf[7'h22] <= 8'h01;
         rf[7'h23] <= 8'hFF;
         rf[7'h40] <= 8'h11;
      end else if (rf_we) begin
         rf[rf_addr] <= rf_wdata;
      end
   end

   // {instr, we, addr, wdata, w_after, skip, zero}
   localparam logic [39:0] VEC [NVEC] = '{
      {14'h301F, 1'b0, 7'h00, 8'h00, 8'h1F, 1'b0, 1'b0},
      {14'h0521, 1'b0, 7'h00, 8'h00, 8'h14, 1'b0, 1'b0},
      {14'h3E24, 1'b0, 7'h00, 8'h00, 8'h38, 1'b0, 1'b0},
      {14'h07A0, 1'b1, 7'h20, 8'h3E, 8'h38, 1'b0, 1'b0},
      {14'h0220, 1'b0, 7'h00, 8'h00, 8'h06, 1'b0, 1'b0},
      {14'h02A2, 1'b1, 7'h22, 8'hFB, 8'h06, 1'b0, 1'b0},
      {14'h0440, 1'b0, 7'h00, 8'h00, 8'h17, 1'b0, 1'b0},
      {14'h3A07, 1'b0, 7'h00, 8'h00, 8'h10, 1'b0, 1'b0},
      {14'h06A1, 1'b1, 7'h21, 8'hE4, 8'h10, 1'b0, 1'b0},
      {14'h0940, 1'b0, 7'h00, 8'h00, 8'hEE, 1'b0, 1'b0},
      {14'h00B0, 1'b1, 7'h30, 8'hEE, 8'hEE, 1'b0, 1'b0},
      {14'h0FA3, 1'b1, 7'h23, 8'h00, 8'hEE, 1'b1, 1'b1},
      {14'h0B23, 1'b0, 7'h00, 8'h00, 8'hFF, 1'b0, 1'b0},
      {14'h03B0, 1'b1, 7'h30, 8'hED, 8'hFF, 1'b0, 1'b0},
      {14'h0A20, 1'b0, 7'h00, 8'h00, 8'h3F, 1'b0, 1'b0},
      {14'h0821, 1'b0, 7'h00, 8'h00, 8'hE4, 1'b0, 1'b0},
      {14'h01A1, 1'b1, 7'h21, 8'h00, 8'hE4, 1'b0, 1'b1},
      {14'h0100, 1'b0, 7'h00, 8'h00, 8'h00, 1'b0, 1'b1},
      {14'h0000, 1'b0, 7'h00, 8'h00, 8'h00, 1'b0, 1'b0},
      {14'h38A5, 1'b0, 7'h00, 8'h00, 8'hA5, 1'b0, 1'b0},
      {14'h390F, 1'b0, 7'h00, 8'h00, 8'h05, 1'b0, 1'b0},
      {14'h3C03, 1'b0, 7'h00, 8'h00, 8'hFE, 1'b0, 1'b0},
      {14'h0BA2, 1'b1, 7'h22, 8'hFA, 8'hFE, 1'b0, 1'b0},
      {14'h3001, 1'b0, 7'h00, 8'h00, 8'h01, 1'b0, 1'b0},
      {14'h00D0, 1'b1, 7'h50, 8'h01, 8'h01, 1'b0, 1'b0},
      {14'h0BD0, 1'b1, 7'h50, 8'h00, 8'h01, 1'b1, 1'b1},
      {14'h3EFF, 1'b0, 7'h00, 8'h00, 8'h00, 1'b0, 1'b1},
      {14'h08C0, 1'b1, 7'h40, 8'h11, 8'h00, 1'b0, 1'b0}
   };

   function automatic string req_of(int i);
      case (i)
         1:           return "R1";
         3, 8:        return "R2";
         4, 5, 21:    return "R5";
         6, 20:       return "R4";
         9:           return "R9";
         10, 18, 24:  return "R6";
         16, 17:      return "R7";
         11, 12, 13, 14, 22, 25: return "R8";
         15, 27:      return "R10";
         26:          return "R11";
         default:     return "R3";
      endcase
   endfunction

   task automatic check(string tag, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic step(logic v, logic [13:0] ins);
      @(negedge clk);
      instr_valid = v;
      instr       = ins;
      #2;
   endtask

   task automatic settle_w();
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fails++;
         n_checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      rst         = 1'b1;
      instr_valid = 1'b0;
      instr       = '0;
      repeat (3) @(posedge clk);
      #1;
      check("R13", "w after reset", w_q, 8'h00);
      @(negedge clk);
      rst = 1'b0;

      for (int i = 0; i < NVEC; i++) begin
         logic [39:0] v;
         v = VEC[i];
         step(1'b1, v[39:26]);
         check(req_of(i), "rf_we", rf_we, v[25]);
         if (v[25]) begin
            check(req_of(i), "rf_addr", rf_addr, v[24:18]);
            check(req_of(i), "rf_wdata", rf_wdata, v[17:10]);
         end
         check(req_of(i), "skip_req", skip_req, v[1]);
         check("R11", "res_zero", res_zero, v[0]);
         settle_w();
         check(req_of(i), "w", w_q, v[9:2]);
      end

      // R12: suppressed instruction has no effect
      step(1'b1, 14'h305A);
      settle_w();
      check("R12", "w preset", w_q, 8'h5A);
      step(1'b0, 14'h07A0);
      check("R12", "idle rf_we", rf_we, 1'b0);
      check("R12", "idle skip", skip_req, 1'b0);
      settle_w();
      check("R12", "idle w", w_q, 8'h5A);
      step(1'b1, 14'h0820);
      settle_w();
      check("R12", "reg 0x20 untouched", w_q, 8'h3E);

      // R12: unused opcode
      step(1'b1, 14'h3FFF);
      check("R12", "unused rf_we", rf_we, 1'b0);
      check("R12", "unused skip", skip_req, 1'b0);
      settle_w();
      check("R12", "unused w", w_q, 8'h3E);

      // R13: reset mid-run
      @(negedge clk);
      instr_valid = 1'b0;
      rst = 1'b1;
      settle_w();
      check("R13", "w after mid reset", w_q, 8'h00);
      @(negedge clk);
      rst = 1'b0;

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

endmodule